// File: doc/BRIEF.md
# Compressed Instruction Mode Sequencer

This block follows the instruction-length mode of a variable-length decode front end. Each cycle the fetch stage presents a 32-bit window. The first halfword of the window is the instruction under decode. From the sequencer state and a handful of control fields in that halfword, the block reports three things: the format to decode the instruction in, how many bits to consume, and the format of the instruction that follows. The state moves forward only when the fetch stage offers an instruction and the decoder takes it.

There are three states. `ST_STD` means persistent standard 32-bit mode. `ST_C16` means 16-bit compressed mode. `ST_ONE_STD` means exactly one standard instruction is owed, after which the block returns to compressed mode. A 10-bit compressed instruction is not a state of its own. In `ST_STD`, a window with a zero prefix is decoded as a 10-bit form, and its trailing flag picks the next state.

The transitions are these:
- From `ST_C16`, the N/M flag pair selects one of: `C16_TO_STD` (N=0, M=0), `C16_STAY` (N=0, M=1), `C16_TO_ONE` (N=1, M=0) or `C16_IMM_STAY` (N=1, M=1).
- From `ST_STD`, a 10-bit form takes `STD_TO_C16` when M=1 and `STD_STAY` otherwise.
- `ST_ONE_STD` always takes `ONE_TO_C16`.
- The locked opcode group takes `LOCK_STAY`.

Top module: `cmp_mode_seq`

## Requirements
- R1: After reset the state is `ST_STD`. A window whose bits 0-4 are not all zero decodes as standard (dec_mode 00), with consume_len 32 and next_mode 00.
- R2: Bit k of the first halfword is fetch_word[31-k]. N is bit 0, the prefix is bits 0-4, the major opcode is bits 5-7, the minor bit is bit 8 and M is bit 15.
- R3: In `ST_STD`, a window with a nonzero prefix gives dec_mode 00, consume_len 32 and next_mode 00.
- R4: In `ST_STD`, a window with a zero prefix is a 10-bit form: dec_mode 10 and consume_len 16. next_mode is 01 (16-bit) when M=1 and 00 when M=0.
- R5: In `ST_C16` with N=0 and M=0, the result is dec_mode 01, consume_len 16 and next_mode 00. Standard mode then persists over later instructions.
- R6: In `ST_C16` with N=0 and M=1, consume_len is 16 and next_mode is 01.
- R7: In `ST_C16` with N=1 and M=0, consume_len is 16 and next_mode is 00. Exactly one standard instruction follows (dec_mode 00, consume_len 32, next_mode 01), even if that window has a zero prefix. Decoding then returns to 16-bit mode.
- R8: In `ST_C16` with N=1 and M=1, consume_len is 32 (a halfword plus its immediate extension) and next_mode is 01.
- R9: When the major.minor field (bits 5-8) is 0011, N and M are ignored and the current mode is kept. A 16-bit form gives next_mode 01. A 10-bit form gives next_mode 00.
- R10: is_nop is 1 only in `ST_C16` when the halfword is 0x8000. The instruction still follows the R7 sequence.
- R11: The state advances only when fetch_valid and decode_ready are both 1. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch window holds an instruction |
| decode_ready | input | 1 | Decoder accepts it this cycle |
| fetch_word | input | 32 | Fetch window; first halfword in bits 31:16 |
| dec_mode | output | 2 | Format of this instruction: 00 standard, 01 16-bit, 10 10-bit |
| consume_len | output | 6 | Bits to consume: 16 or 32 |
| next_mode | output | 2 | Format of the following instruction |
| is_nop | output | 1 | 16-bit nop detected |

## Verification
The bench puts a zero-prefix window behind the N=1, M=0 case. A design that checked for the 10-bit form before the owed standard instruction would decode that window as 10-bit and lose the return to compressed mode. The bench sends the locked group with flag pairs that would otherwise switch mode, in both the 16-bit and the 10-bit form; a design that failed to mask the flags would leave the current mode. It also holds a mode-changing instruction through valid-low and ready-low cycles; a design that advanced on either signal alone would switch early. Finally it checks 0x0000 in 16-bit mode and 0x8000 in standard mode, where a loose nop match would raise is_nop.

// File: rtl/cmp_seq_pkg.sv
package cmp_seq_pkg;

    typedef enum logic [1:0] {
        DM_STD = 2'b00,
        DM_C16 = 2'b01,
        DM_C10 = 2'b10
    } dec_mode_e;

    typedef enum logic [1:0] {
        ST_STD     = 2'b00,
        ST_C16     = 2'b01,
        ST_ONE_STD = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic n_flag;
        logic m_flag;
        logic zero_prefix;
        logic locked;
        logic nop_form;
    } hw_fields_t;

endpackage

// File: rtl/cmp_hw_fields.sv
module cmp_hw_fields
    import cmp_seq_pkg::*;
#(
    parameter int HW_W       = 16,
    parameter int PREFIX_W   = 5,
    parameter int MAJ_POS    = 5,
    parameter int MAJMIN_W   = 4,
    parameter logic [3:0] LOCK_CODE = 4'b0011
) (
    input  logic [HW_W-1:0] hw,
    output hw_fields_t      fields
);
    // bit k in instruction numbering is hw[HW_W-1-k]
    localparam int PFX_LO = HW_W - PREFIX_W;
    localparam int MM_HI  = HW_W - 1 - MAJ_POS;
    localparam int MM_LO  = MM_HI - MAJMIN_W + 1;

    logic [MAJMIN_W-1:0] majmin;

    always_comb begin
        majmin             = hw[MM_HI:MM_LO];
        fields.n_flag      = hw[HW_W-1];
        fields.m_flag      = hw[0];
        fields.zero_prefix = (hw[HW_W-1:PFX_LO] == '0);
        fields.locked      = (majmin == LOCK_CODE[MAJMIN_W-1:0]);
        fields.nop_form    = (hw == {1'b1, {(HW_W-1){1'b0}}});
    end

endmodule

// File: rtl/cmp_mode_next.sv
module cmp_mode_next
    import cmp_seq_pkg::*;
(
    input  seq_state_e state,
    input  hw_fields_t fields,
    output dec_mode_e  dec_mode,
    output logic       long_len,
    output seq_state_e nxt_state,
    output logic       nop_hit
);
    always_comb begin
        dec_mode  = DM_STD;
        long_len  = 1'b1;
        nxt_state = ST_STD;
        nop_hit   = 1'b0;
        unique case (state)
            ST_C16: begin
                dec_mode = DM_C16;
                long_len = 1'b0;
                nop_hit  = fields.nop_form;
                if (fields.locked) begin
                    nxt_state = ST_C16;                 // LOCK_STAY
                end else begin
                    unique case ({fields.n_flag, fields.m_flag})
                        2'b00: nxt_state = ST_STD;      // C16_TO_STD
                        2'b01: nxt_state = ST_C16;      // C16_STAY
                        2'b10: nxt_state = ST_ONE_STD;  // C16_TO_ONE
                        default: begin
                            nxt_state = ST_C16;         // C16_IMM_STAY
                            long_len  = 1'b1;
                        end
                    endcase
                end
            end
            ST_ONE_STD: begin
                nxt_state = ST_C16;                     // ONE_TO_C16
            end
            default: begin
                if (fields.zero_prefix) begin
                    dec_mode  = DM_C10;
                    long_len  = 1'b0;
                    nxt_state = (fields.m_flag && !fields.locked) ? ST_C16 : ST_STD;
                end
            end
        endcase
    end

endmodule

// File: rtl/cmp_mode_seq.sv
module cmp_mode_seq
    import cmp_seq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HW_W   = 16,
    parameter int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic              decode_ready,
    input  logic [WORD_W-1:0] fetch_word,
    output logic [1:0]        dec_mode,
    output logic [LEN_W-1:0]  consume_len,
    output logic [1:0]        next_mode,
    output logic              is_nop
);
    seq_state_e state, nxt_state;
    hw_fields_t fields;
    dec_mode_e  dmode;
    logic       long_len;
    logic       nop_hit;
    logic       accept;

    assign accept = fetch_valid && decode_ready;

    cmp_hw_fields #(.HW_W(HW_W)) u_fields (
        .hw     (fetch_word[WORD_W-1 -: HW_W]),
        .fields (fields)
    );

    cmp_mode_next u_next (
        .state     (state),
        .fields    (fields),
        .dec_mode  (dmode),
        .long_len  (long_len),
        .nxt_state (nxt_state),
        .nop_hit   (nop_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      state <= ST_STD;
        else if (accept) state <= nxt_state;
    end

    always_comb begin
        dec_mode    = dmode;
        consume_len = long_len ? LEN_W'(WORD_W) : LEN_W'(HW_W);
        is_nop      = nop_hit;
        unique case (nxt_state)
            ST_C16:  next_mode = DM_C16;
            default: next_mode = DM_STD;
        endcase
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> state == $past(state));                                   // R11
    AST_ONE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state == ST_ONE_STD) |=> state == ST_C16);                 // R7
    AST_LOCK_C16: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state == ST_C16 && fields.locked) |=> state == ST_C16);    // R9
    AST_NOP_C16_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop |-> dec_mode == DM_C16);                                       // R10
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        consume_len == LEN_W'(HW_W) || consume_len == LEN_W'(WORD_W));        // R8
    AST_ONE_IS_STD: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ONE_STD |-> (dec_mode == DM_STD && next_mode == DM_C16)); // R7

endmodule

// File: tb/cmp_mode_seq_tb.sv
module cmp_mode_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        decode_ready = 1'b0;
    logic [31:0] fetch_word = '0;
    logic [1:0]  dec_mode;
    logic [5:0]  consume_len;
    logic [1:0]  next_mode;
    logic        is_nop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_mode_seq u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .decode_ready(decode_ready), .fetch_word(fetch_word),
        .dec_mode(dec_mode), .consume_len(consume_len),
        .next_mode(next_mode), .is_nop(is_nop)
    );

    // {valid, ready, word, exp_dec, exp_len, exp_next, exp_nop, req}
    localparam int NV = 19;
    localparam logic [48:0] VEC [NV] = '{
        {1'b1,1'b1,32'h7C00_0000,2'd0,6'd32,2'd0,1'b0,4'd1},  // R1 R3 standard after reset
        {1'b1,1'b1,32'h0201_0000,2'd2,6'd16,2'd1,1'b0,4'd4},  // R4 R2 10-bit, M=1
        {1'b1,1'b1,32'h0301_0000,2'd1,6'd16,2'd1,1'b0,4'd6},  // R6
        {1'b1,1'b0,32'h0500_0000,2'd1,6'd16,2'd0,1'b0,4'd11}, // R11 ready low
        {1'b0,1'b1,32'h0500_0000,2'd1,6'd16,2'd0,1'b0,4'd11}, // R11 valid low
        {1'b1,1'b1,32'h8401_0000,2'd1,6'd32,2'd1,1'b0,4'd8},  // R8
        {1'b1,1'b1,32'h8180_0000,2'd1,6'd16,2'd1,1'b0,4'd9},  // R9 locked, N=1 M=0
        {1'b1,1'b1,32'h8000_0000,2'd1,6'd16,2'd0,1'b1,4'd10}, // R10 nop then one std
        {1'b1,1'b1,32'h0001_0000,2'd0,6'd32,2'd1,1'b0,4'd7},  // R7 owed std, zero prefix
        {1'b1,1'b1,32'h0500_0000,2'd1,6'd16,2'd0,1'b0,4'd5},  // R5
        {1'b1,1'b1,32'h4800_0000,2'd0,6'd32,2'd0,1'b0,4'd5},  // R5 persists
        {1'b1,1'b1,32'h0181_0000,2'd2,6'd16,2'd0,1'b0,4'd9},  // R9 locked 10-bit, M=1
        {1'b1,1'b1,32'h0200_0000,2'd2,6'd16,2'd0,1'b0,4'd4},  // R4 10-bit, M=0
        {1'b1,1'b1,32'h0201_0000,2'd2,6'd16,2'd1,1'b0,4'd4},  // R4
        {1'b1,1'b1,32'h0180_0000,2'd1,6'd16,2'd1,1'b0,4'd9},  // R9 locked, N=0 M=0
        {1'b1,1'b1,32'h0000_0000,2'd1,6'd16,2'd0,1'b0,4'd10}, // R10 N=0 not nop
        {1'b1,1'b1,32'h8000_0000,2'd0,6'd32,2'd0,1'b0,4'd10}, // R10 std mode not nop
        {1'b0,1'b1,32'h0201_0000,2'd2,6'd16,2'd1,1'b0,4'd11}, // R11 no accept
        {1'b1,1'b1,32'h7C00_0000,2'd0,6'd32,2'd0,1'b0,4'd11}  // R11 state held
    };

    task automatic check(input int req, input logic [1:0] ed, input logic [5:0] el,
                         input logic [1:0] en, input logic enop);
        checks++;
        if (dec_mode !== ed || consume_len !== el || next_mode !== en || is_nop !== enop) begin
            errors++;
            $display("FAIL R%0d: got dec=%0d len=%0d next=%0d nop=%0d, expected dec=%0d len=%0d next=%0d nop=%0d",
                     req, dec_mode, consume_len, next_mode, is_nop, ed, el, en, enop);
        end
    endtask

    task automatic apply(input logic v, input logic r, input logic [31:0] w);
        @(negedge clk);
        fetch_valid = v; decode_ready = r; fetch_word = w;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][48], VEC[i][47], VEC[i][46:15]);
            check(int'(VEC[i][3:0]), VEC[i][14:13], VEC[i][12:7], VEC[i][6:5], VEC[i][4]);
        end
        // R1: reset from 16-bit mode returns to standard
        apply(1'b1, 1'b1, 32'h0201_0000);
        apply(1'b1, 1'b1, 32'h0301_0000);
        check(1, 2'd1, 6'd16, 2'd1, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        fetch_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        apply(1'b1, 1'b1, 32'h7C00_0000);
        check(1, 2'd0, 6'd32, 2'd0, 1'b0);
        // R7: two owed-std cycles stalled still owe exactly one
        apply(1'b1, 1'b1, 32'h0201_0000);
        apply(1'b1, 1'b1, 32'h8000_0000);
        apply(1'b0, 1'b0, 32'h0001_0000);
        check(7, 2'd0, 6'd32, 2'd1, 1'b0);
        apply(1'b1, 1'b1, 32'h7C00_0000);
        check(7, 2'd0, 6'd32, 2'd1, 1'b0);
        apply(1'b1, 1'b1, 32'h0301_0000);
        check(7, 2'd1, 6'd16, 2'd1, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (10000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule